// File: doc/BRIEF.md
# Center-Aligned Low-Side PWM Pulse Generator

This block drives one low-side PWM output from a period timer whose count is signed and centred on zero. Software programs a period, an operating mode, two signed duty values and a dead-time amount through a small write port. The duty values mark where the pulse turns on and off relative to the count. Every setting is staged in shadow registers and takes effect only at a period boundary, so a reprogrammed duty never produces a glitch in the middle of a period.

A duty value that lies outside the range the current period allows is not compared at all. The output is instead held at a fixed level for the whole period, and a sticky status flag records the over-modulation or under-modulation until software clears it. The dead-time amount only widens the allowed duty range here. Inserting dead time between complementary outputs is done elsewhere.

Top module: `lspwm_gen`

## Requirements
- R1: A synchronous active-high `rst` clears every shadow and active register and the counter. While `rst` is high and on the cycle after it, `pwm_lo`, `ovm_flag` and `unm_flag` are 0.
- R2: With H = period >> 1, the count steps by +1 from -H to H-1 in modes 01, 10 and 11, giving a 2H-cycle period. In mode 00 it counts up from -H to H-1, holds H-1 for one more cycle, and then counts down to -H, giving a 4H-cycle period. When H is 0 the count stays at 0 and every cycle is a period boundary.
- R3: In mode 00 with in-range settings, `pwm_lo` is 1 exactly when the count of the previous cycle is less than duty0. This applies on both slopes, so the pulse is mirrored about the period centre.
- R4: In modes 01, 10 and 11 with in-range settings, `pwm_lo` becomes 1 when the previous count is below duty0. It becomes 0 when that count is above duty1. Otherwise it keeps its level.
- R5: Writes go to shadow registers. Period, mode, duty and dead-time values are copied to the active set only on the cycle after the last count of a period. A write made in the middle of a period has no effect on `pwm_lo` until the next period starts.
- R6: With active dead time D, the valid duty range is -(H+D) to H+D inclusive in modes 00 and 01, and -H to H inclusive in modes 10 and 11. Only duty0 is range-checked in mode 00. Both duties are range-checked in the other modes.
- R7: If a checked duty value is below the valid range, `pwm_lo` is 1 on every cycle of that period and `ovm_flag` sets.
- R8: If no checked duty value is below the range but one is above it, `pwm_lo` is 0 on every cycle of that period and `unm_flag` sets.
- R9: Both flags are sticky. A write to address 5 clears `ovm_flag` and a write to address 6 clears `unm_flag`, and in both cases the data is ignored. A flag whose condition still holds sets again on the following cycle.
- R10: The register addresses are 0 period (unsigned), 1 mode (data bits [1:0]), 2 duty0, 3 duty1 and 4 dead time (unsigned). The mode codes are 00 symmetrical, 01 asymmetrical, 10 left half and 11 right half.
- R11: Duty values are 16-bit two's-complement counts in clock periods, so a write of 16'hFFFD means -3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_lo | output | 1 | Low-side pulse output, registered |
| ovm_flag | output | 1 | Sticky over-modulation flag |
| unm_flag | output | 1 | Sticky under-modulation flag |

## Verification
The hardest situation to reach from the ports is a write landing a few cycles before a period boundary. One example is changing the mode from symmetrical to left half while a duty sits inside the widened range but outside the narrow one. The new range check and the forced output level must then appear exactly at the next boundary. To get there, the stimulus uses short periods together with a high write rate, so that random writes often fall next to a wrap. Directed steps also place duty values just inside and just outside the range with and without dead time. A cycle-accurate reference model in the bench, built from the requirements, predicts all three outputs on every cycle.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;

  typedef enum logic [1:0] {
    MD_SYM   = 2'b00,
    MD_ASYM  = 2'b01,
    MD_LEFT  = 2'b10,
    MD_RIGHT = 2'b11
  } pwm_mode_e;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_PERIOD = 3'd0;
  localparam logic [REG_AW-1:0] A_MODE   = 3'd1;
  localparam logic [REG_AW-1:0] A_DUTY0  = 3'd2;
  localparam logic [REG_AW-1:0] A_DUTY1  = 3'd3;
  localparam logic [REG_AW-1:0] A_DEAD   = 3'd4;
  localparam logic [REG_AW-1:0] A_CLR_OV = 3'd5;
  localparam logic [REG_AW-1:0] A_CLR_UN = 3'd6;

endpackage

// File: rtl/lspwm_regs.sv
module lspwm_regs
  import lspwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 load,
  output logic [DW-1:0]        nxt_period,
  output logic [DW-1:0]        act_period,
  output logic [DW-1:0]        act_dead,
  output pwm_mode_e            act_mode,
  output logic signed [DW-1:0] act_d0,
  output logic signed [DW-1:0] act_d1,
  output logic                 clr_ovm,
  output logic                 clr_unm
);

  logic [DW-1:0]        sh_period, sh_dead;
  pwm_mode_e            sh_mode;
  logic signed [DW-1:0] sh_d0, sh_d1;

  // shadow set, written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_period <= '0;
      sh_dead   <= '0;
      sh_mode   <= MD_SYM;
      sh_d0     <= '0;
      sh_d1     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PERIOD: sh_period <= wr_data;
        A_MODE:   sh_mode   <= pwm_mode_e'(wr_data[1:0]);
        A_DUTY0:  sh_d0     <= signed'(wr_data);
        A_DUTY1:  sh_d1     <= signed'(wr_data);
        A_DEAD:   sh_dead   <= wr_data;
        default:  ;
      endcase
    end
  end

  // active set, copied only at a period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      act_period <= '0;
      act_dead   <= '0;
      act_mode   <= MD_SYM;
      act_d0     <= '0;
      act_d1     <= '0;
    end else if (load) begin
      act_period <= sh_period;
      act_dead   <= sh_dead;
      act_mode   <= sh_mode;
      act_d0     <= sh_d0;
      act_d1     <= sh_d1;
    end
  end

  assign nxt_period = sh_period;
  assign clr_ovm    = wr_en && (wr_addr == A_CLR_OV);
  assign clr_unm    = wr_en && (wr_addr == A_CLR_UN);

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_d0) && $stable(act_d1) && $stable(act_mode)
               && $stable(act_period) && $stable(act_dead)));

endmodule

// File: rtl/lspwm_timer.sv
module lspwm_timer
  import lspwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        half,
  input  logic [DW-1:0]        nxt_half,
  input  pwm_mode_e            mode,
  output logic signed [DW:0]   cnt,
  output logic                 load
);

  localparam int CW = DW + 1;

  logic                 down;
  logic signed [CW-1:0] h_s, nh_s, top;

  assign h_s  = signed'({1'b0, half});
  assign nh_s = signed'({1'b0, nxt_half});
  assign top  = h_s - 1;

  always_comb begin
    if (half == '0)           load = 1'b1;
    else if (mode != MD_SYM)  load = (cnt == top);
    else                      load = down && (cnt == -h_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (load) begin
      cnt  <= -nh_s;
      down <= 1'b0;
    end else if ((mode == MD_SYM) && !down && (cnt == top)) begin
      down <= 1'b1;
    end else if (down) begin
      cnt <= cnt - 1;
    end else begin
      cnt <= cnt + 1;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (half != '0) |-> ((cnt >= -h_s) && (cnt < h_s)));

  // R2
  cnt_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && (mode != MD_SYM)) |=> (cnt == $past(cnt) + 1));

  // R2
  cnt_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && down) |=> (cnt == $past(cnt) - 1));

endmodule

// File: rtl/lspwm_edge.sv
module lspwm_edge
  import lspwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW:0]   cnt,
  input  logic [DW-1:0]        half,
  input  logic [DW-1:0]        dead,
  input  pwm_mode_e            mode,
  input  logic signed [DW-1:0] d0,
  input  logic signed [DW-1:0] d1,
  input  logic                 clr_ovm,
  input  logic                 clr_unm,
  output logic                 pwm_lo,
  output logic                 ovm,
  output logic                 unm
);

  localparam int EW = DW + 2;

  logic signed [EW-1:0] cx, d0x, d1x, lim, nlim;
  logic                 widen, both, below, above;

  assign cx    = {cnt[DW], cnt};
  assign d0x   = {{2{d0[DW-1]}}, d0};
  assign d1x   = {{2{d1[DW-1]}}, d1};
  assign widen = (mode == MD_SYM) || (mode == MD_ASYM);
  assign both  = (mode != MD_SYM);
  assign lim   = signed'({2'b00, half}) + (widen ? signed'({2'b00, dead}) : '0);
  assign nlim  = -lim;
  assign below = (d0x < nlim) || (both && (d1x < nlim));
  assign above = !below && ((d0x > lim) || (both && (d1x > lim)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_lo <= 1'b0;
      ovm    <= 1'b0;
      unm    <= 1'b0;
    end else begin
      if (below)            pwm_lo <= 1'b1;
      else if (above)       pwm_lo <= 1'b0;
      else if (!both)       pwm_lo <= (cx < d0x);
      else if (cx < d0x)    pwm_lo <= 1'b1;
      else if (cx > d1x)    pwm_lo <= 1'b0;
      ovm <= (ovm && !clr_ovm) || below;
      unm <= (unm && !clr_unm) || above;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!pwm_lo && !ovm && !unm));

  // R7
  ovm_force_chk: assert property (@(posedge clk) disable iff (rst)
    below |=> (pwm_lo && ovm));

  // R8
  unm_force_chk: assert property (@(posedge clk) disable iff (rst)
    above |=> (!pwm_lo && unm));

  // R9
  ovm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovm && !clr_ovm) |=> ovm);

  // R9
  unm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (unm && !clr_unm) |=> unm);

endmodule

// File: rtl/lspwm_gen.sv
module lspwm_gen
  import lspwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              pwm_lo,
  output logic              ovm_flag,
  output logic              unm_flag
);

  logic [DW-1:0]        nxt_period, act_period, act_dead, half, nxt_half;
  pwm_mode_e            act_mode;
  logic signed [DW-1:0] act_d0, act_d1;
  logic signed [DW:0]   cnt;
  logic                 load, clr_ovm, clr_unm;

  assign half     = act_period >> 1;
  assign nxt_half = nxt_period >> 1;

  lspwm_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .load       (load),
    .nxt_period (nxt_period),
    .act_period (act_period),
    .act_dead   (act_dead),
    .act_mode   (act_mode),
    .act_d0     (act_d0),
    .act_d1     (act_d1),
    .clr_ovm    (clr_ovm),
    .clr_unm    (clr_unm)
  );

  lspwm_timer #(.DW(DW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .half     (half),
    .nxt_half (nxt_half),
    .mode     (act_mode),
    .cnt      (cnt),
    .load     (load)
  );

  lspwm_edge #(.DW(DW)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .half    (half),
    .dead    (act_dead),
    .mode    (act_mode),
    .d0      (act_d0),
    .d1      (act_d1),
    .clr_ovm (clr_ovm),
    .clr_unm (clr_unm),
    .pwm_lo  (pwm_lo),
    .ovm     (ovm_flag),
    .unm     (unm_flag)
  );

endmodule

// File: tb/lspwm_gen_bench.sv
module lspwm_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_lo, ovm_flag, unm_flag;

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 0;
  string phase   = "R1";

  always #5 clk = ~clk;

  lspwm_gen u_lspwm_gen (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pwm_lo   (pwm_lo),
    .ovm_flag (ovm_flag),
    .unm_flag (unm_flag)
  );

  // reference model built from the requirements
  int s_per, s_mode, s_d0, s_d1, s_dt;
  int a_per, a_mode, a_d0, a_d1, a_dt;
  int m_cnt;
  bit m_down, m_out, m_ovm, m_unm;
  string m_tag = "R1";
  int h, lim;
  bit chk1, blw, abv, term;

  always @(posedge clk) begin
    if (rst) begin
      s_per = 0; s_mode = 0; s_d0 = 0; s_d1 = 0; s_dt = 0;
      a_per = 0; a_mode = 0; a_d0 = 0; a_d1 = 0; a_dt = 0;
      m_cnt = 0; m_down = 0; m_out = 0; m_ovm = 0; m_unm = 0;
      m_tag = "R1";
    end else begin
      h    = a_per / 2;
      lim  = h + ((a_mode < 2) ? a_dt : 0);          // R6
      chk1 = (a_mode != 0);
      blw  = (a_d0 < -lim) || (chk1 && (a_d1 < -lim));
      abv  = !blw && ((a_d0 > lim) || (chk1 && (a_d1 > lim)));
      if (blw)             begin m_out = 1; m_tag = "R7 R6"; end
      else if (abv)        begin m_out = 0; m_tag = "R8 R6"; end
      else if (!chk1)      begin m_out = (m_cnt < a_d0); m_tag = "R2 R3"; end
      else begin
        m_tag = "R2 R4";
        if (m_cnt < a_d0) m_out = 1;
        else if (m_cnt > a_d1) m_out = 0;
      end
      m_ovm = (m_ovm && !(wr_en && wr_addr == 3'd5)) || blw;   // R9
      m_unm = (m_unm && !(wr_en && wr_addr == 3'd6)) || abv;
      if (h == 0)          term = 1;
      else if (a_mode != 0) term = (m_cnt == h - 1);
      else                 term = m_down && (m_cnt == -h);
      if (term) begin                                         // R5
        a_per = s_per; a_mode = s_mode; a_d0 = s_d0; a_d1 = s_d1; a_dt = s_dt;
        m_cnt = -(a_per / 2); m_down = 0;
      end else if (a_mode == 0 && !m_down && m_cnt == h - 1) m_down = 1;
      else if (m_down) m_cnt = m_cnt - 1;
      else m_cnt = m_cnt + 1;
      if (wr_en) begin                                        // R10 R11
        case (wr_addr)
          3'd0: s_per  = int'(wr_data);
          3'd1: s_mode = int'(wr_data[1:0]);
          3'd2: s_d0   = int'($signed(wr_data));
          3'd3: s_d1   = int'($signed(wr_data));
          3'd4: s_dt   = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit we, logic [2:0] a, logic [15:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    chk({phase, " pwm_lo ", m_tag}, int'(pwm_lo), int'(m_out));
    chk({phase, " ovm_flag R7 R9"}, int'(ovm_flag), int'(m_ovm));
    chk({phase, " unm_flag R8 R9"}, int'(unm_flag), int'(m_unm));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 3'd0, 16'd0);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    cyc(1, a, d);
  endtask

  function automatic logic [15:0] rnd_data(logic [2:0] a);
    case (a)
      3'd0:    return 16'($urandom_range(0, 40));
      3'd1:    return 16'($urandom_range(0, 3));
      3'd2, 3'd3: return 16'(int'($urandom_range(0, 50)) - 25);
      3'd4:    return 16'($urandom_range(0, 6));
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    int seed_init;
    seed_init = $urandom(32'd4711);
    phase = "R1 reset";
    rst = 1;
    @(negedge clk);
    cyc(0, 3'd0, 16'd0);
    rst = 0;
    idle(3);

    phase = "R10 R11 asym";
    wr(3'd0, 16'd20);
    wr(3'd1, 16'd1);
    wr(3'd2, 16'hFFFD);
    wr(3'd3, 16'd4);
    idle(60);

    phase = "R3 sym";
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd2);
    idle(90);

    phase = "R6 left narrow";
    wr(3'd4, 16'd4);
    wr(3'd1, 16'd2);
    wr(3'd2, 16'hFFF4);
    idle(30);
    phase = "R6 asym widened";
    wr(3'd5, 16'd0);
    wr(3'd1, 16'd1);
    idle(30);
    wr(3'd5, 16'd0);
    idle(25);

    phase = "R8 above";
    wr(3'd3, 16'd30);
    idle(30);

    phase = "R9 clear";
    wr(3'd3, 16'd4);
    idle(25);
    wr(3'd6, 16'hFFFF);
    idle(10);

    phase = "R5 midperiod";
    wr(3'd0, 16'd40);
    idle(45);
    for (int i = 0; i < 30; i++) begin
      wr(3'd2, rnd_data(3'd2));
      idle(6);
    end

    phase = "R2 zero period";
    wr(3'd0, 16'd0);
    idle(10);
    wr(3'd0, 16'd7);
    idle(20);

    phase = "random R2 R5";
    for (int i = 0; i < 5000; i++) begin
      if ($urandom_range(0, 799) == 0) begin
        phase = "random R1";
        rst = 1;
        cyc(0, 3'd0, 16'd0);
        rst = 0;
        phase = "random R2 R5";
      end else if ($urandom_range(0, 5) == 0) begin
        logic [2:0] a;
        a = 3'($urandom_range(0, 7));
        wr(a, rnd_data(a));
      end else begin
        idle(1);
      end
    end
    done = 1;
  end

  initial begin
    for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule